// File: doc/BRIEF.md
# Zero-Run Literal Stream Compressor

This block compresses a byte stream in which most bytes are zero, such as a configuration image, into a simple run/literal code. A small decoder can expand that code again with almost no work. Bytes enter through a valid/ready port, and a flag on the final byte marks the end of the stream. Coded bytes leave through a second valid/ready port.

Each stretch of zero bytes becomes a single count byte. Stretches of other data become a header byte followed by the data itself. Short gaps of zeros inside data are kept inside a literal block, because splitting the block there would cost more bytes than it saves. A three-byte window in front of the encoder shows it whether a zero starts a real run. Literal bytes wait in a buffer until their block closes, because the header, which carries the final length, must go out first. When the stream ends, the output is padded with zero bytes up to a multiple of four. A new stream may follow at once without a reset.

Top module: `zr_compress`

## Requirements
- R1: A run of zero bytes is coded as one byte whose value is the run length, from 1 to 127. A run longer than 127 is split into several such bytes, each up to 127 long, in stream order.
- R2: A literal block is coded as the byte 0x80 plus its length (1 to 127), followed by the block's input bytes in their original order. A block is never longer than 127 bytes.
- R3: Inside a literal block, a zero byte at block position p (counting from 0) stays in the block if p + 2 < 127, both of the next two input bytes exist, and at least one of them is nonzero. The byte right after that zero then joins the block without being examined.
- R4: A literal block closes on the first zero byte that does not meet the R3 condition, when it holds 127 bytes, or when the stream ends. Encoding then goes back to zero-run counting.
- R5: After the last code of a stream, 0x00 bytes are added until the number of output bytes for that stream is a multiple of 4. No bytes are added when it already is.
- R6: While a closed literal block is being sent (its header and data), i_ready stays low.
- R7: While o_valid is high and o_ready is low, o_valid stays high and o_data does not change.
- R8: Right after reset, o_valid is low and i_ready is high.
- R9: Back-to-back streams, each ended by i_last, are coded independently. Each stream's output decodes exactly to its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_data | input | 8 | Raw input byte |
| i_last | input | 1 | Marks the final byte of a stream |
| i_valid | input | 1 | Input byte offered |
| i_ready | output | 1 | Block takes the input byte this cycle |
| o_data | output | 8 | Coded output byte |
| o_valid | output | 1 | Output byte offered |
| o_ready | input | 1 | Sink takes the output byte this cycle |

## Verification
The checks assume that every stream holds at least one byte and that i_last marks exactly one byte in each stream. They also assume that the sink does not need o_data to change while it holds o_ready low. The bench meets these assumptions: every stream it drives is non-empty, and i_last is raised only on the final byte. It inserts random input gaps and random output stalls, but it never sends a byte after i_last before that stream's padding has drained.

// File: rtl/zr_pkg.sv
package zr_pkg;
  typedef enum logic [2:0] {
    ST_SCAN,
    ST_HDR,
    ST_RD,
    ST_WR,
    ST_PAD
  } zr_state_e;

  localparam logic [7:0] ZR_LIT_FLAG = 8'h80;
  localparam int         ZR_WIN      = 3;
endpackage

// File: rtl/zr_window.sv
module zr_window #(
  parameter int DEPTH = 3,
  parameter int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [7:0]        push_data,
  input  logic [CNTW-1:0]   pop,
  output logic [CNTW-1:0]   cnt,
  output logic [DEPTH*8-1:0] win
);
  logic [7:0]      q  [DEPTH];
  logic [7:0]      nq [DEPTH];
  logic [CNTW-1:0] left;
  logic [CNTW-1:0] ncnt;

  always_comb begin
    left = cnt - pop;
    ncnt = push ? left + 1'b1 : left;
    for (int i = 0; i < DEPTH; i++) begin
      if (push && i == int'(left))
        nq[i] = push_data;
      else if (i + int'(pop) < DEPTH)
        nq[i] = q[i + int'(pop)];
      else
        nq[i] = 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else begin
      cnt <= ncnt;
    end
    for (int i = 0; i < DEPTH; i++) q[i] <= nq[i];
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_out
    assign win[g*8 +: 8] = q[g];
  end

  AST_WIN_POP: assert property (@(posedge clk) disable iff (rst)
    pop <= cnt);                                   // R2
  AST_WIN_PUSH: assert property (@(posedge clk) disable iff (rst)
    push |-> int'(cnt - pop) < DEPTH);            // R2
endmodule

// File: rtl/zr_litbuf.sv
module zr_litbuf #(
  parameter int DEPTH = 127,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [7:0]    wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [7:0]    rd
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re) rd <= mem[ra];
  end
endmodule

// File: rtl/zr_compress.sv
module zr_compress
  import zr_pkg::*;
#(
  parameter int LEN_MAX = 127
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] i_data,
  input  logic       i_last,
  input  logic       i_valid,
  output logic       i_ready,
  output logic [7:0] o_data,
  output logic       o_valid,
  input  logic       o_ready
);
  localparam int CW   = $clog2(LEN_MAX + 1);
  localparam int WCW  = $clog2(ZR_WIN + 1);

  zr_state_e st, st_n;
  logic          mode_lit, mode_n;
  logic [CW-1:0] zc, zc_n, lc, lc_n, rp, rp_n;
  logic          frc, frc_n;
  logic          seen_last, sl_clear;
  logic [1:0]    ocnt;

  logic [WCW-1:0]      wcnt, pop;
  logic [ZR_WIN*8-1:0] win;
  logic [7:0]          w0, w1, w2, rdata, eb;
  logic                push, emit, we, re, out_free, ready_dec, drained;

  assign w0 = win[7:0];
  assign w1 = win[15:8];
  assign w2 = win[23:16];

  assign out_free  = !o_valid || o_ready;
  assign ready_dec = (int'(wcnt) == ZR_WIN) || (seen_last && wcnt != '0);
  assign drained   = seen_last && wcnt == '0;
  assign i_ready   = (st == ST_SCAN) && !seen_last && (int'(wcnt) < ZR_WIN);
  assign push      = i_valid && i_ready;

  zr_window #(.DEPTH(ZR_WIN)) u_win (
    .clk(clk), .rst(rst), .push(push), .push_data(i_data),
    .pop(pop), .cnt(wcnt), .win(win)
  );

  zr_litbuf #(.DEPTH(LEN_MAX), .AW(CW)) u_buf (
    .clk(clk), .we(we), .wa(lc), .wd(w0),
    .re(re), .ra(rp), .rd(rdata)
  );

  always_comb begin
    st_n = st; mode_n = mode_lit; zc_n = zc; lc_n = lc; rp_n = rp;
    frc_n = frc; sl_clear = 1'b0; pop = '0; emit = 1'b0; eb = 8'h00;
    we = 1'b0; re = 1'b0;
    case (st)
      ST_SCAN: begin
        if (drained) begin
          if (!mode_lit && zc != '0) begin
            if (out_free) begin emit = 1'b1; eb = 8'(zc); zc_n = '0; end
          end else if (mode_lit) begin
            st_n = ST_HDR; mode_n = 1'b0;
          end else begin
            st_n = ST_PAD;
          end
        end else if (ready_dec) begin
          if (!mode_lit) begin
            if (w0 == 8'h00) begin
              if (int'(zc) == LEN_MAX) begin
                if (out_free) begin
                  emit = 1'b1; eb = 8'(zc); zc_n = CW'(1); pop = WCW'(1);
                end
              end else begin
                zc_n = zc + 1'b1; pop = WCW'(1);
              end
            end else if (zc != '0) begin
              if (out_free) begin
                emit = 1'b1; eb = 8'(zc); zc_n = '0; mode_n = 1'b1;
              end
            end else begin
              mode_n = 1'b1;
            end
          end else begin
            if (int'(lc) == LEN_MAX) begin
              st_n = ST_HDR; mode_n = 1'b0;
            end else if (w0 != 8'h00 || frc) begin
              we = 1'b1; lc_n = lc + 1'b1; pop = WCW'(1); frc_n = 1'b0;
            end else if (int'(wcnt) == ZR_WIN && int'(lc) + 2 < LEN_MAX &&
                         (w1 != 8'h00 || w2 != 8'h00)) begin
              we = 1'b1; lc_n = lc + 1'b1; pop = WCW'(1); frc_n = 1'b1;
            end else begin
              st_n = ST_HDR; mode_n = 1'b0;
            end
          end
        end
      end
      ST_HDR: begin
        if (out_free) begin
          emit = 1'b1; eb = ZR_LIT_FLAG | 8'(lc); rp_n = '0; st_n = ST_RD;
        end
      end
      ST_RD: begin
        re = 1'b1; st_n = ST_WR;
      end
      ST_WR: begin
        if (out_free) begin
          emit = 1'b1; eb = rdata; rp_n = rp + 1'b1;
          if (rp + 1'b1 == lc) begin st_n = ST_SCAN; lc_n = '0; end
          else st_n = ST_RD;
        end
      end
      ST_PAD: begin
        if (ocnt == 2'd0) begin
          st_n = ST_SCAN; sl_clear = 1'b1;
        end else if (out_free) begin
          emit = 1'b1; eb = 8'h00;
        end
      end
      default: st_n = ST_SCAN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_SCAN; mode_lit <= 1'b0; zc <= '0; lc <= '0; rp <= '0;
      frc <= 1'b0; seen_last <= 1'b0; ocnt <= 2'd0;
      o_valid <= 1'b0; o_data <= 8'h00;
    end else begin
      st <= st_n; mode_lit <= mode_n; zc <= zc_n; lc <= lc_n; rp <= rp_n;
      frc <= frc_n;
      if (push && i_last) seen_last <= 1'b1;
      else if (sl_clear) seen_last <= 1'b0;
      if (emit) begin
        o_valid <= 1'b1; o_data <= eb; ocnt <= ocnt + 1'b1;
      end else if (o_ready) begin
        o_valid <= 1'b0;
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    o_valid && !o_ready |=> o_valid && $stable(o_data));          // R7
  AST_RUN_RANGE: assert property (@(posedge clk) disable iff (rst)
    emit && st == ST_SCAN |-> eb != 8'h00 && eb <= 8'(LEN_MAX));  // R1
  AST_HDR_LEN: assert property (@(posedge clk) disable iff (rst)
    emit && st == ST_HDR |-> lc != '0 && int'(lc) <= LEN_MAX);    // R2
  AST_WIN_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RD || st == ST_WR) |=> wcnt == $past(wcnt));        // R6
  AST_PAD_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(seen_last) |-> ocnt == 2'd0);                           // R5
endmodule

// File: tb/sim_zr_compress.sv
module sim_zr_compress;
  typedef logic [7:0] bq_t[$];

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] i_data;
  logic       i_last, i_valid, i_ready;
  logic [7:0] o_data;
  logic       o_valid, o_ready;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  zr_compress u0 (
    .clk(clk), .rst(rst), .i_data(i_data), .i_last(i_last),
    .i_valid(i_valid), .i_ready(i_ready),
    .o_data(o_data), .o_valid(o_valid), .o_ready(o_ready)
  );

  // {in_len[4], in bytes[64] first byte high, out_len[4], out bytes[64]}
  localparam int NVEC = 8;
  localparam logic [135:0] TBL [NVEC] = '{
    {4'd3, 64'h000000_0000000000, 4'd4, 64'h03000000_00000000},  // R1 R5
    {4'd1, 64'h05000000_00000000, 4'd4, 64'h81050000_00000000},  // R2
    {4'd3, 64'h070009_0000000000, 4'd8, 64'h81070181_09000000},  // R4
    {4'd4, 64'h0700090A_00000000, 4'd8, 64'h84070009_0A000000},  // R3
    {4'd5, 64'h0700000B_0C000000, 4'd8, 64'h85070000_0B0C0000},  // R3
    {4'd5, 64'h07000000_0B000000, 4'd8, 64'h81070381_0B000000},  // R4
    {4'd4, 64'h01020304_00000000, 4'd8, 64'h84010203_04000000},  // R5
    {4'd8, 64'h00000000_09000000, 4'd4, 64'h04810903_00000000}   // R5
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bq_t ref_encode(bq_t s);
    bq_t o;
    int i = 0;
    int n = s.size();
    while (i < n) begin
      while (i < n && s[i] == 8'h00) begin
        int z = 0;
        while (z < 127 && i + z < n && s[i+z] == 8'h00) z++;
        o.push_back(8'(z));
        i += z;
      end
      begin
        int rv = 0;
        int mx = (n - i < 127) ? n - i : 127;
        bit stop = 1'b0;
        while (rv < mx && !stop) begin
          if (s[i+rv] == 8'h00) begin
            if (rv + 2 < mx && (s[i+rv+1] != 8'h00 || s[i+rv+2] != 8'h00)) rv += 2;
            else stop = 1'b1;
          end else begin
            rv++;
          end
        end
        if (rv > 0) begin
          o.push_back(8'(128 + rv));
          for (int k = 0; k < rv; k++) o.push_back(s[i+k]);
          i += rv;
        end
      end
    end
    while (o.size() % 4 != 0) o.push_back(8'h00);
    return o;
  endfunction

  function automatic bq_t ref_decode(bq_t c);
    bq_t o;
    int i = 0;
    while (i < c.size()) begin
      if (c[i] < 8'h80) begin
        for (int k = 0; k < int'(c[i]); k++) o.push_back(8'h00);
        i++;
      end else begin
        int cnt = int'(c[i]) - 128;
        for (int k = 0; k < cnt && i + 1 + k < c.size(); k++) o.push_back(c[i+1+k]);
        i += cnt + 1;
      end
    end
    return o;
  endfunction

  task automatic run_stream(input bq_t s, input bq_t exp, input int hold,
                            input string req);
    bq_t got;
    int idx = 0;
    int cyc = 0;
    int idle = 0;
    bit hold_ok = 1'b1;
    bit pstall = 1'b0;
    logic [7:0] pd = 8'h00;
    bit ordy;
    int bad = -1;
    while (1) begin
      @(negedge clk);
      if (pstall && !(o_valid && o_data == pd)) hold_ok = 1'b0;
      if (hold > 0 && cyc == hold) begin
        chk(!i_ready, "R6", "i_ready during stalled block", int'(i_ready), 0);
        chk(o_valid && o_data == exp[0], "R6", "header held at output",
            int'(o_data), int'(exp[0]));
      end
      ordy = (cyc < hold) ? 1'b0 : ($urandom % 4 != 0);
      if (o_valid && ordy) got.push_back(o_data);
      pstall = o_valid && !ordy;
      pd = o_data;
      o_ready = ordy;
      if (idx < s.size() && ($urandom % 5 != 0)) begin
        i_valid = 1'b1;
        i_data  = s[idx];
        i_last  = (idx == s.size() - 1);
        if (i_ready) idx++;
      end else begin
        i_valid = 1'b0;
        i_last  = 1'b0;
      end
      cyc++;
      if (idx == s.size() && got.size() >= exp.size()) idle++;
      if (idle >= 24) break;
      if (cyc > 20000) begin
        chk(1'b0, req, "stream timeout", got.size(), exp.size());
        break;
      end
    end
    i_valid = 1'b0;
    i_last  = 1'b0;
    chk(got.size() == exp.size(), req, "output length", got.size(), exp.size());
    for (int k = 0; k < exp.size() && k < got.size(); k++)
      if (bad < 0 && got[k] != exp[k]) bad = k;
    if (bad >= 0)
      chk(1'b0, req, $sformatf("byte %0d", bad), int'(got[bad]), int'(exp[bad]));
    else
      chk(1'b1, req, "bytes", 0, 0);
    chk(ref_decode(got) == s, "R9", "round trip decode", got.size(), s.size());
    chk(hold_ok, "R7", "output held under stall", 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    bq_t s;
    bq_t e;
    rst = 1'b1; i_valid = 1'b0; i_last = 1'b0; i_data = 8'h00; o_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!o_valid, "R8", "o_valid after reset", int'(o_valid), 0);
    chk(i_ready, "R8", "i_ready after reset", int'(i_ready), 1);

    // table walk: hand-derived codes
    for (int v = 0; v < NVEC; v++) begin
      s = {}; e = {};
      for (int k = 0; k < int'(TBL[v][135:132]); k++) s.push_back(TBL[v][131-8*k -: 8]);
      for (int k = 0; k < int'(TBL[v][67:64]); k++) e.push_back(TBL[v][63-8*k -: 8]);
      run_stream(s, e, 0, "R1R2R3R4R5 table");
    end

    // R6: sink stalled while a closed block waits to drain
    s = '{8'h01, 8'h02, 8'h03, 8'h00, 8'h00, 8'h00, 8'h05};
    run_stream(s, ref_encode(s), 40, "R6");

    // R1: long zero run split into 127-byte pieces
    s = {};
    for (int k = 0; k < 300; k++) s.push_back(8'h00);
    run_stream(s, ref_encode(s), 0, "R1");

    // R2: nonzero data over the block length limit
    s = {};
    for (int k = 0; k < 130; k++) s.push_back(8'(k % 255 + 1));
    run_stream(s, ref_encode(s), 0, "R2");

    // R4: zero at block position 125 cannot be absorbed
    s = {};
    for (int k = 0; k < 125; k++) s.push_back(8'h5A);
    s.push_back(8'h00); s.push_back(8'h11); s.push_back(8'h22);
    run_stream(s, ref_encode(s), 0, "R4");

    // R3: zero at position 123 absorbed with forced follower
    s = {};
    for (int k = 0; k < 123; k++) s.push_back(8'hA5);
    s.push_back(8'h00); s.push_back(8'h00); s.push_back(8'h05); s.push_back(8'h06);
    run_stream(s, ref_encode(s), 0, "R3");

    // R9: random sparse streams back to back, no reset between
    for (int r = 0; r < 12; r++) begin
      int len = 1 + $urandom % 400;
      s = {};
      for (int k = 0; k < len; k++)
        s.push_back(($urandom % 3 == 0) ? 8'($urandom % 256) : 8'h00);
      run_stream(s, ref_encode(s), 0, "R9");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule